// File: doc/BRIEF.md
# Phase-Shifted Multi-String PWM Generator

This block drives four LED-string enable lines from one free-running period counter. A 3-bit string-configuration code sets how many strings run from the common display duty word and where each string's pulse sits within the period. Spreading the pulse start times across the period lowers the peak load on the supply rail. Channels in a display group share one duty word. The other channels become cluster channels: each has its own duty word and enable, and a disabled one stays dark.

The period is 2^RES_HI counter clocks when the high-resolution select is set and 2^RES_LO clocks otherwise. By default these are 13 and 10 bits, which gives about 4.9 kHz and 39 kHz from a 40 MHz counter clock. All inputs pass through shadow registers that load only in the last count of a period. Changing a setting therefore never cuts a pulse short or adds a stray pulse in the middle of a period.

Top module: `pspwm_gen`

## Requirements
- R1: A synchronous active-low reset clears the counter and all shadow registers, so every output is low while reset is held. Outputs stay low for the whole first period after release, because the shadow duty words are zero.
- R2: The period is 8192 clocks when the high-resolution select is 1 and 1024 clocks when it is 0. Over any full period, a channel with duty d below the period is high for exactly d clocks, in one contiguous run.
- R3: Code 000: all four channels are display channels. Channel k turns on k·P/4 clocks after channel 0.
- R4: Code 001: channels 0, 1 and 2 are display channels at offsets 0, round(P/3) and round(2P/3), which is 341 and 683 at P=1024, and 2731 and 5461 at P=8192. Channel 3 is a cluster channel.
- R5: Code 010: channels 0 and 1 are display channels at offsets 0 and P/2. Channels 2 and 3 are cluster channels.
- R6: Code 011: only channel 0 is a display channel. Channels 1 to 3 are cluster channels.
- R7: Code 100: all four channels are display channels. Channels 0 and 1 sit at offset 0 and channels 2 and 3 at offset P/2, so each pair switches together.
- R8: Code 101: all four channels are display channels at offset 0 and are always equal.
- R9: Code 110: channels 0 and 1 are display channels at offset 0. Channels 2 and 3 are cluster channels.
- R10: Code 111: all channels are cluster channels. In every code, a cluster channel k uses offset k·P/4 and duty word k of the cluster duty input.
- R11: A cluster channel whose enable bit (bit k of the cluster enable input) is 0 stays low, whatever its cluster duty word holds.
- R12: A duty of 0 keeps a channel low for the whole period. A duty equal to or above P keeps it high for the whole period.
- R13: Code, resolution select, duty words and enables take effect only from the first count of the next period. A change made in the middle of a period does not alter the rest of that period.
- R14: Each output is registered. Channel k is high in the clock after a counter value n for which (n − offset_k) mod P is below its duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| str_cfg_i | input | 3 | String-configuration code |
| hires_i | input | 1 | 1 selects the 2^RES_HI period, 0 the 2^RES_LO period |
| disp_duty_i | input | RES_HI+1 | Duty word shared by the display channels |
| clus_duty_i | input | 4×(RES_HI+1) | Per-channel cluster duty words, word k for channel k |
| clus_en_i | input | 4 | Per-channel cluster enables |
| pwm_o | output | 4 | String enable outputs, bit k for channel k |

## Verification
The bench measures the distance between rising edges of channel pairs. A decoder that picked the wrong slot, or truncated P/3 instead of rounding it, shows up as a gap that is one or many clocks off, at both period lengths. The duty extremes are checked because an off-by-one comparison would leave a one-clock glitch at duty 0 or a one-clock gap at full duty. A duty word wider than the period is checked too, since a masked compare would wrap it to a short pulse. The bench also changes the duty word right after a pulse starts and counts the rest of that pulse. A design without shadowing would cut that pulse short, and one that latched at the wrong point would shift the period boundary.

// File: rtl/pspwm_pkg.sv
package pspwm_pkg;

    localparam int NUM_STR = 4;

    // string-configuration codes
    typedef enum logic [2:0] {
        CFG_QUAD     = 3'b000,
        CFG_TRI      = 3'b001,
        CFG_DUO      = 3'b010,
        CFG_SOLO     = 3'b011,
        CFG_PAIRS    = 3'b100,
        CFG_ALL_TIED = 3'b101,
        CFG_TWIN     = 3'b110,
        CFG_CLUSTER  = 3'b111
    } str_cfg_e;

    // phase position of a lane inside the period
    typedef enum logic [2:0] {
        SLOT_ZERO,
        SLOT_QTR,
        SLOT_HALF,
        SLOT_3QTR,
        SLOT_THIRD,
        SLOT_2THIRD
    } slot_e;

    typedef struct packed {
        logic  disp;
        slot_e slot;
    } lane_cfg_t;

endpackage

// File: rtl/pspwm_cfg_decode.sv
module pspwm_cfg_decode
    import pspwm_pkg::*;
(
    input  str_cfg_e                   cfg_i,
    output lane_cfg_t [NUM_STR-1:0]    lane_o
);

    function automatic slot_e quarter_slot(input int k);
        case (k)
            0:       return SLOT_ZERO;
            1:       return SLOT_QTR;
            2:       return SLOT_HALF;
            default: return SLOT_3QTR;
        endcase
    endfunction

    always_comb begin
        // default: every lane is a cluster lane in its quarter slot
        for (int k = 0; k < NUM_STR; k++) begin
            lane_o[k].disp = 1'b0;
            lane_o[k].slot = quarter_slot(k);
        end
        unique case (cfg_i)
            CFG_QUAD: begin
                for (int k = 0; k < NUM_STR; k++) lane_o[k].disp = 1'b1;
            end
            CFG_TRI: begin
                lane_o[0].disp = 1'b1;
                lane_o[1].disp = 1'b1;
                lane_o[1].slot = SLOT_THIRD;
                lane_o[2].disp = 1'b1;
                lane_o[2].slot = SLOT_2THIRD;
            end
            CFG_DUO: begin
                lane_o[0].disp = 1'b1;
                lane_o[1].disp = 1'b1;
                lane_o[1].slot = SLOT_HALF;
            end
            CFG_SOLO: begin
                lane_o[0].disp = 1'b1;
            end
            CFG_PAIRS: begin
                for (int k = 0; k < NUM_STR; k++) begin
                    lane_o[k].disp = 1'b1;
                    lane_o[k].slot = (k < NUM_STR/2) ? SLOT_ZERO : SLOT_HALF;
                end
            end
            CFG_ALL_TIED: begin
                for (int k = 0; k < NUM_STR; k++) begin
                    lane_o[k].disp = 1'b1;
                    lane_o[k].slot = SLOT_ZERO;
                end
            end
            CFG_TWIN: begin
                lane_o[0].disp = 1'b1;
                lane_o[1].disp = 1'b1;
                lane_o[1].slot = SLOT_ZERO;
            end
            CFG_CLUSTER: begin
            end
        endcase
    end

endmodule

// File: rtl/pspwm_lane.sv
module pspwm_lane
    import pspwm_pkg::*;
#(
    parameter int RES_HI = 13,
    parameter int RES_LO = 10
) (
    input  logic [RES_HI-1:0] cnt_i,
    input  logic              hires_i,
    input  slot_e             slot_i,
    input  logic [RES_HI:0]   duty_i,
    output logic              on_o
);

    localparam int P_HI = 1 << RES_HI;
    localparam int P_LO = 1 << RES_LO;

    localparam logic [RES_HI-1:0] MASK_HI  = RES_HI'(P_HI - 1);
    localparam logic [RES_HI-1:0] MASK_LO  = RES_HI'(P_LO - 1);
    localparam logic [RES_HI-1:0] QTR_HI   = RES_HI'(P_HI / 4);
    localparam logic [RES_HI-1:0] QTR_LO   = RES_HI'(P_LO / 4);
    localparam logic [RES_HI-1:0] HALF_HI  = RES_HI'(P_HI / 2);
    localparam logic [RES_HI-1:0] HALF_LO  = RES_HI'(P_LO / 2);
    localparam logic [RES_HI-1:0] TQTR_HI  = RES_HI'(3 * P_HI / 4);
    localparam logic [RES_HI-1:0] TQTR_LO  = RES_HI'(3 * P_LO / 4);
    // power-of-two periods never divide by 3: adding 1 rounds to nearest
    localparam logic [RES_HI-1:0] THIRD_HI = RES_HI'((P_HI + 1) / 3);
    localparam logic [RES_HI-1:0] THIRD_LO = RES_HI'((P_LO + 1) / 3);
    localparam logic [RES_HI-1:0] TTHR_HI  = RES_HI'((2 * P_HI + 1) / 3);
    localparam logic [RES_HI-1:0] TTHR_LO  = RES_HI'((2 * P_LO + 1) / 3);

    logic [RES_HI-1:0] offset;
    logic [RES_HI-1:0] mask;
    logic [RES_HI-1:0] phase;

    always_comb begin
        unique case (slot_i)
            SLOT_QTR:    offset = hires_i ? QTR_HI   : QTR_LO;
            SLOT_HALF:   offset = hires_i ? HALF_HI  : HALF_LO;
            SLOT_3QTR:   offset = hires_i ? TQTR_HI  : TQTR_LO;
            SLOT_THIRD:  offset = hires_i ? THIRD_HI : THIRD_LO;
            SLOT_2THIRD: offset = hires_i ? TTHR_HI  : TTHR_LO;
            default:     offset = '0;
        endcase
        mask  = hires_i ? MASK_HI : MASK_LO;
        phase = (cnt_i - offset) & mask;
        on_o  = {1'b0, phase} < duty_i;
    end

endmodule

// File: rtl/pspwm_gen.sv
module pspwm_gen
    import pspwm_pkg::*;
#(
    parameter int RES_HI = 13,
    parameter int RES_LO = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [2:0]                      str_cfg_i,
    input  logic                            hires_i,
    input  logic [RES_HI:0]                 disp_duty_i,
    input  logic [NUM_STR-1:0][RES_HI:0]    clus_duty_i,
    input  logic [NUM_STR-1:0]              clus_en_i,
    output logic [NUM_STR-1:0]              pwm_o
);

    localparam int CW = RES_HI;
    localparam int DW = RES_HI + 1;
    localparam logic [CW-1:0] LAST_HI = CW'((1 << RES_HI) - 1);
    localparam logic [CW-1:0] LAST_LO = CW'((1 << RES_LO) - 1);

    typedef struct packed {
        logic [CW-1:0]              cnt;
        logic [2:0]                 cfg;
        logic                       hires;
        logic [DW-1:0]              dduty;
        logic [NUM_STR-1:0][DW-1:0] cduty;
        logic [NUM_STR-1:0]         cen;
        logic [NUM_STR-1:0]         pwm;
    } state_t;

    state_t st_d, st_q;

    lane_cfg_t [NUM_STR-1:0]    lane_cfg;
    logic [NUM_STR-1:0][DW-1:0] lane_duty;
    logic [NUM_STR-1:0]         lane_on;
    logic                       wrap;

    pspwm_cfg_decode u_decode (
        .cfg_i  (str_cfg_e'(st_q.cfg)),
        .lane_o (lane_cfg)
    );

    always_comb begin
        for (int k = 0; k < NUM_STR; k++) begin
            if (lane_cfg[k].disp)
                lane_duty[k] = st_q.dduty;
            else if (st_q.cen[k])
                lane_duty[k] = st_q.cduty[k];
            else
                lane_duty[k] = '0;
        end
    end

    for (genvar g = 0; g < NUM_STR; g++) begin : g_lane
        pspwm_lane #(
            .RES_HI (RES_HI),
            .RES_LO (RES_LO)
        ) u_lane (
            .cnt_i   (st_q.cnt),
            .hires_i (st_q.hires),
            .slot_i  (lane_cfg[g].slot),
            .duty_i  (lane_duty[g]),
            .on_o    (lane_on[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        wrap     = st_q.cnt == (st_q.hires ? LAST_HI : LAST_LO);
        st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
        if (wrap) begin
            st_d.cfg   = str_cfg_i;
            st_d.hires = hires_i;
            st_d.dduty = disp_duty_i;
            st_d.cduty = clus_duty_i;
            st_d.cen   = clus_en_i;
        end
        st_d.pwm = lane_on;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pwm_o = st_q.pwm;

endmodule

// File: rtl/pspwm_chk.sv
module pspwm_chk #(
    parameter int RES_HI = 13,
    parameter int RES_LO = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        pwm_o,
    input logic [RES_HI-1:0] cnt_q,
    input logic [2:0]        cfg_q,
    input logic              hires_q,
    input logic [RES_HI:0]   dduty_q,
    input logic [3:0]        cen_q
);

    localparam logic [RES_HI-1:0] LAST_HI = RES_HI'((1 << RES_HI) - 1);
    localparam logic [RES_HI-1:0] LAST_LO = RES_HI'((1 << RES_LO) - 1);
    localparam logic [RES_HI:0]   P_HI    = (RES_HI+1)'(1 << RES_HI);
    localparam logic [RES_HI:0]   P_LO    = (RES_HI+1)'(1 << RES_LO);

    logic [RES_HI-1:0] last_cnt;
    logic [RES_HI:0]   period;
    assign last_cnt = hires_q ? LAST_HI : LAST_LO;
    assign period   = hires_q ? P_HI : P_LO;

    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> pwm_o == 4'b0000);

    a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_cnt);

    a_r13_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != last_cnt |=> $stable(cfg_q) && $stable(hires_q) && $stable(dduty_q));

    a_r7_pairs_match: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q == 3'b100 |=> (pwm_o[0] == pwm_o[1]) && (pwm_o[2] == pwm_o[3]));

    a_r8_all_tied: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q == 3'b101 |=> (pwm_o == 4'b0000) || (pwm_o == 4'b1111));

    a_r11_cluster_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == 3'b111) && (cen_q == 4'b0000) |=> pwm_o == 4'b0000);

    a_r12_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == 3'b101) && (dduty_q == '0) |=> pwm_o == 4'b0000);

    a_r12_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == 3'b101) && (dduty_q >= period) |=> pwm_o == 4'b1111);

endmodule

bind pspwm_gen pspwm_chk #(
    .RES_HI (RES_HI),
    .RES_LO (RES_LO)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_o   (pwm_o),
    .cnt_q   (st_q.cnt),
    .cfg_q   (st_q.cfg),
    .hires_q (st_q.hires),
    .dduty_q (st_q.dduty),
    .cen_q   (st_q.cen)
);

// File: tb/pspwm_gen_tb.sv
`timescale 1ns/1ps
module pspwm_gen_tb_top;

    localparam int RES_HI = 13;
    localparam int RES_LO = 10;
    localparam int DW     = RES_HI + 1;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [2:0]            str_cfg_i = 3'b000;
    logic                  hires_i = 1'b0;
    logic [DW-1:0]         disp_duty_i = '0;
    logic [3:0][DW-1:0]    clus_duty_i = '0;
    logic [3:0]            clus_en_i = '0;
    logic [3:0]            pwm_o;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    pspwm_gen #(.RES_HI(RES_HI), .RES_LO(RES_LO)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .str_cfg_i   (str_cfg_i),
        .hires_i     (hires_i),
        .disp_duty_i (disp_duty_i),
        .clus_duty_i (clus_duty_i),
        .clus_en_i   (clus_en_i),
        .pwm_o       (pwm_o)
    );

    // ---------------- behavioural reference ----------------
    int       m_cnt, m_mode, m_hi, m_dd, m_ce;
    int       m_cd [4];
    logic [3:0] exp_pwm = 4'b0000;
    bit       armed = 1'b0;

    function automatic bit ref_disp(input int mode, input int k);
        case (mode)
            0, 4, 5: return 1'b1;
            1:       return k < 3;
            2, 6:    return k < 2;
            3:       return k == 0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int ref_off(input int mode, input int k, input int p);
        if (mode == 1 && k == 1) return (p + 1) / 3;
        if (mode == 1 && k == 2) return (2 * p + 1) / 3;
        if (mode == 2 && k == 1) return p / 2;
        if (mode == 4)           return (k >= 2) ? p / 2 : 0;
        if (mode == 5)           return 0;
        if (mode == 6 && k == 1) return 0;
        return k * p / 4;
    endfunction

    always @(posedge clk) begin
        armed = 1'b1;
        if (!rst_n) begin
            m_cnt = 0; m_mode = 0; m_hi = 0; m_dd = 0; m_ce = 0;
            for (int k = 0; k < 4; k++) m_cd[k] = 0;
            exp_pwm = 4'b0000;
        end else begin
            int p;
            p = m_hi ? (1 << RES_HI) : (1 << RES_LO);
            for (int k = 0; k < 4; k++) begin
                int duty, ph;
                if (ref_disp(m_mode, k)) duty = m_dd;
                else if (m_ce[k])        duty = m_cd[k];
                else                     duty = 0;
                ph = (m_cnt - ref_off(m_mode, k, p) + p) % p;
                exp_pwm[k] = ph < duty;
            end
            if (m_cnt == p - 1) begin
                m_cnt  = 0;
                m_mode = int'(str_cfg_i);
                m_hi   = int'(hires_i);
                m_dd   = int'(disp_duty_i);
                m_ce   = int'(clus_en_i);
                for (int k = 0; k < 4; k++) m_cd[k] = int'(clus_duty_i[k]);
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    // every-clock comparison, R14 plus the phase under test
    always @(negedge clk) begin
        if (armed) begin
            n_checks++;
            if (pwm_o !== exp_pwm) begin
                n_errors++;
                $display("FAIL R14/%s cycle compare: pwm_o=%b expected=%b", cur_req, pwm_o, exp_pwm);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic count_high(input int ch, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o[ch]) c++;
        end
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        @(negedge clk);
        prev = pwm_o[ch];
        forever begin
            @(negedge clk);
            if (!prev && pwm_o[ch]) break;
            prev = pwm_o[ch];
        end
    endtask

    task automatic lag(input int a, input int b, output int d);
        logic prev;
        wait_rise(a);
        d = 0;
        prev = pwm_o[b];
        forever begin
            @(negedge clk);
            d++;
            if (!prev && pwm_o[b]) break;
            prev = pwm_o[b];
        end
    endtask

    task automatic set_cfg(input int mode, input int hi, input int dd);
        @(negedge clk);
        str_cfg_i   = 3'(mode);
        hires_i     = hi[0];
        disp_duty_i = DW'(dd);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int c, d;
        clus_duty_i[0] = 14'd100;
        clus_duty_i[1] = 14'd200;
        clus_duty_i[2] = 14'd400;
        clus_duty_i[3] = 14'd700;
        clus_en_i      = 4'b1011;   // channel 2 cluster disabled
        disp_duty_i    = 14'd300;
        repeat (5) @(negedge clk);
        check("R1", "outputs in reset", int'(pwm_o), 0);
        rst_n = 1'b1;

        cur_req = "R1";
        count_high(0, 1000, c);
        check("R1", "ch0 highs in first period", c, 0);

        cur_req = "R3";
        repeat (1100) @(negedge clk);
        lag(0, 1, d); check("R3", "lag ch0->ch1", d, 256);
        lag(0, 2, d); check("R3", "lag ch0->ch2", d, 512);
        lag(0, 3, d); check("R3", "lag ch0->ch3", d, 768);
        cur_req = "R2";
        count_high(0, 1024, c); check("R2", "ch0 highs per 1024 period", c, 300);

        cur_req = "R4";
        set_cfg(1, 0, 300); repeat (2100) @(negedge clk);
        lag(0, 1, d); check("R4", "lag ch0->ch1", d, 341);
        lag(0, 2, d); check("R4", "lag ch0->ch2", d, 683);
        count_high(3, 1024, c); check("R4", "ch3 cluster highs", c, 700);

        cur_req = "R5";
        set_cfg(2, 0, 300); repeat (2100) @(negedge clk);
        lag(0, 1, d); check("R5", "lag ch0->ch1", d, 512);
        count_high(2, 1024, c); check("R11", "disabled cluster ch2 highs", c, 0);
        count_high(3, 1024, c); check("R5", "ch3 cluster highs", c, 700);

        cur_req = "R6";
        set_cfg(3, 0, 300); repeat (2100) @(negedge clk);
        count_high(0, 1024, c); check("R6", "ch0 display highs", c, 300);
        count_high(1, 1024, c); check("R6", "ch1 cluster highs", c, 200);

        cur_req = "R7";
        set_cfg(4, 0, 300); repeat (2100) @(negedge clk);
        lag(0, 2, d); check("R7", "lag ch0->ch2", d, 512);
        count_high(1, 1024, c); check("R7", "ch1 display highs", c, 300);

        cur_req = "R8";
        set_cfg(5, 0, 300); repeat (2100) @(negedge clk);
        count_high(3, 1024, c); check("R8", "ch3 display highs", c, 300);

        cur_req = "R9";
        set_cfg(6, 0, 300); repeat (2100) @(negedge clk);
        count_high(1, 1024, c); check("R9", "ch1 display highs", c, 300);
        count_high(3, 1024, c); check("R9", "ch3 cluster highs", c, 700);

        cur_req = "R10";
        set_cfg(7, 0, 300); repeat (2100) @(negedge clk);
        lag(0, 1, d); check("R10", "lag ch0->ch1", d, 256);
        count_high(0, 1024, c); check("R10", "ch0 cluster highs", c, 100);
        count_high(2, 1024, c); check("R11", "disabled cluster ch2 highs", c, 0);

        cur_req = "R12";
        set_cfg(0, 0, 0); repeat (2100) @(negedge clk);
        count_high(0, 1024, c); check("R12", "duty 0 highs", c, 0);
        set_cfg(0, 0, 1024); repeat (2100) @(negedge clk);
        count_high(1, 1024, c); check("R12", "duty = period highs", c, 1024);
        set_cfg(0, 0, 5000); repeat (2100) @(negedge clk);
        count_high(2, 1024, c); check("R12", "duty > period highs", c, 1024);

        cur_req = "R2";
        set_cfg(5, 1, 3000); repeat (1100) @(negedge clk);
        count_high(0, 8192, c); check("R2", "ch0 highs per 8192 period", c, 3000);

        cur_req = "R4";
        set_cfg(1, 1, 3000); repeat (8300) @(negedge clk);
        lag(0, 1, d); check("R4", "hi-res lag ch0->ch1", d, 2731);
        lag(0, 2, d); check("R4", "hi-res lag ch0->ch2", d, 5461);

        cur_req = "R13";
        set_cfg(5, 0, 300); repeat (8300) @(negedge clk);
        repeat (1100) @(negedge clk);
        wait_rise(0);
        disp_duty_i = 14'd0;
        count_high(0, 512, c); check("R13", "rest of pulse after mid-period change", c, 299);
        repeat (1100) @(negedge clk);
        count_high(0, 1024, c); check("R13", "next period uses new duty", c, 0);

        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        finish_run();
    end

endmodule